// File: doc/BRIEF.md
# ADC Scan Channel Sequencer

This block chooses which analog input an ADC converts, and when. A one-byte configuration register holds a 5-bit start-channel code, two reserved bits that must stay zero, and an internal-source select bit (bit 7). In single mode a start trigger converts the one channel named by the code. In scan mode a start trigger converts four consecutive channels in ascending order, beginning at the code. For each step the sequencer drives a channel number with a convert request. It waits for the converter's done handshake and then emits the result tag: the channel number, a last-step flag and a discard flag.

The block guards its configuration. Scan start codes in the gap between the two channel banks are refused. So is a window that would convert a channel taken by an external reference. Writes with reserved bits set are rejected and flagged. A change of the internal-source bit while the converter is enabled is also rejected and flagged. After the internal source is switched on, the first result is marked for discard. Dropping the converter enable aborts a scan at once. A start that arrives during a scan is dropped and recorded in a sticky overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, cfg_q is 0x00, conv_req, res_valid, wr_err and overrun are 0, and the first scan-mode start converts channels 0, 1, 2 and 3.
- R2: In scan mode a start converts four steps on channels code, code+1, code+2 and code+3 in that order. res_last is 1 only on the fourth result.
- R3: In single mode a start converts exactly one step on channel code, and that result carries res_last=1.
- R4: In scan mode the legal codes are 0..12 and 16..20. In single mode they are 0..23. Any other code raises cfg_err, and a start is then ignored (conv_req stays 0).
- R5: A write with cfg_wdata[6] or cfg_wdata[5] set leaves cfg_q unchanged, and wr_err is 1 for the one cycle after the write.
- R6: A write that would change cfg_q[7] while conv_en=1 is rejected with a wr_err pulse. A write that keeps cfg_q[7] is accepted while conv_en=1.
- R7: After an accepted write that changes cfg_q[7] from 0 to 1, the next result has res_discard=1, and the results after it have res_discard=0.
- R8: With refp_ext=1, a window that includes channel 0 raises cfg_err. With refn_ext=1, a window that includes channel 1 raises cfg_err. In either case a start is ignored. The window is the four scan channels, or the single channel in single mode.
- R9: A start while a conversion sequence is in progress does not disturb it. It sets overrun, which stays 1 until reset.
- R10: With conv_en=0, conv_req is 0 from the next cycle on, no further results appear, and the next start begins again at step 0.
- R11: conv_req stays 1 and chan_sel stays stable until conv_done. res_valid rises one cycle after the cycle in which conv_req and conv_done are both 1, and res_chan equals the chan_sel of that cycle.
- R12: A start while conv_en=0 is ignored and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_en | input | 1 | Converter enable; low aborts any sequence |
| scan_mode | input | 1 | 1 = four-step scan, 0 = single channel |
| refp_ext | input | 1 | External positive reference in use (claims channel 0) |
| refn_ext | input | 1 | External negative reference in use (claims channel 1) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Write data: [7] internal source, [6:5] reserved, [4:0] code |
| start | input | 1 | Start trigger |
| conv_done | input | 1 | Conversion finished handshake from the converter |
| cfg_q | output | 8 | Current configuration register |
| wr_err | output | 1 | One-cycle pulse: last write rejected |
| cfg_err | output | 1 | Current configuration is not scannable |
| overrun | output | 1 | Sticky: a start arrived during a sequence |
| conv_req | output | 1 | Convert request to the converter |
| chan_sel | output | 5 | Channel being converted |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 5 | Channel of the result |
| res_last | output | 1 | Result is the final step of its sequence |
| res_discard | output | 1 | Result must be thrown away |

## Verification
The hardest case to reach is a discard flag placed on the correct result. Setting the internal-source bit is only legal with the converter disabled. The enable must then be raised again without a second change of the bit, and a full scan must follow. The stimulus drops conv_en, sets bit 7, re-enables and rewrites the same value to show that this write is accepted. It then runs a scan and expects the discard flag on the first step only. The abort case is reached by dropping conv_en halfway through a scan while a done pulse is still held high. This shows that the late handshake yields no result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W        = 5;
  localparam int CFG_W       = 8;
  localparam int INT_BIT     = 7;
  localparam int RSV_HI      = 6;
  localparam int RSV_LO      = 5;
  localparam int SCAN_LEN    = 4;
  localparam int LO_LAST     = 12;
  localparam int HI_FIRST    = 16;
  localparam int HI_LAST     = 20;
  localparam int SINGLE_LAST = 23;
  localparam int REFP_CH     = 0;
  localparam int REFN_CH     = 1;

  typedef enum logic {SQ_IDLE, SQ_BUSY} sq_state_e;

  function automatic logic scan_code_ok(input logic [CH_W-1:0] c);
    return (int'(c) <= LO_LAST) || ((int'(c) >= HI_FIRST) && (int'(c) <= HI_LAST));
  endfunction

  function automatic logic single_code_ok(input logic [CH_W-1:0] c);
    return int'(c) <= SINGLE_LAST;
  endfunction

  function automatic logic in_window(input logic [CH_W-1:0] base, input int span, input int ch);
    return (int'(base) <= ch) && (ch < int'(base) + span);
  endfunction

  function automatic logic [CH_W-1:0] step_chan(input logic [CH_W-1:0] base, input int step);
    return CH_W'(int'(base) + step);
  endfunction
endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             conv_en,
  input  logic             res_evt,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wr_err,
  output logic             discard_pend
);
  logic int_chg, rsv_bad, wr_reject, wr_accept;

  assign int_chg   = wdata[INT_BIT] != cfg_q[INT_BIT];
  assign rsv_bad   = wdata[RSV_HI] | wdata[RSV_LO];
  assign wr_reject = we && (rsv_bad || (int_chg && conv_en));
  assign wr_accept = we && !wr_reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      wr_err       <= 1'b0;
      discard_pend <= 1'b0;
    end else begin
      wr_err <= wr_reject;
      if (wr_accept) cfg_q <= wdata;
      if (wr_accept && int_chg) discard_pend <= wdata[INT_BIT];
      else if (res_evt)         discard_pend <= 1'b0;
    end
  end

  // R5
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $stable(cfg_q));
  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[RSV_HI:RSV_LO] == 2'b00);
  // R6
  int_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_en) |-> $stable(cfg_q[INT_BIT]));
endmodule

// File: rtl/adc_cfg_check.sv
module adc_cfg_check
  import adc_seq_pkg::*;
(
  input  logic [CH_W-1:0] base,
  input  logic            scan_mode,
  input  logic            refp_ext,
  input  logic            refn_ext,
  output logic            code_bad,
  output logic            ref_clash,
  output logic            cfg_err
);
  int span;
  always_comb begin
    span      = scan_mode ? SCAN_LEN : 1;
    code_bad  = scan_mode ? !scan_code_ok(base) : !single_code_ok(base);
    ref_clash = (refp_ext && in_window(base, span, REFP_CH)) ||
                (refn_ext && in_window(base, span, REFN_CH));
    cfg_err   = code_bad || ref_clash;
  end
endmodule

// File: rtl/adc_step_fsm.sv
module adc_step_fsm
  import adc_seq_pkg::*;
#(
  parameter int STEPS  = SCAN_LEN,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_en,
  input  logic            scan_mode,
  input  logic [CH_W-1:0] base,
  input  logic            cfg_err,
  input  logic            start,
  input  logic            conv_done,
  input  logic            discard_pend,
  output logic            conv_req,
  output logic [CH_W-1:0] chan_sel,
  output logic            step_done,
  output logic            res_valid,
  output logic [CH_W-1:0] res_chan,
  output logic            res_last,
  output logic            res_discard,
  output logic            overrun
);
  sq_state_e         state;
  logic [STEP_W-1:0] step;
  logic [CH_W-1:0]   base_q;
  logic              mode_q;
  logic              start_ok, start_clash, last_step;

  assign conv_req    = (state == SQ_BUSY);
  assign chan_sel    = step_chan(base_q, int'(step));
  assign start_ok    = start && conv_en && !cfg_err && (state == SQ_IDLE);
  assign start_clash = start && conv_en && (state == SQ_BUSY);
  assign step_done   = conv_req && conv_en && conv_done;
  assign last_step   = mode_q ? (step == STEP_W'(STEPS - 1)) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      step   <= '0;
      base_q <= '0;
      mode_q <= 1'b0;
    end else if (!conv_en) begin
      state <= SQ_IDLE;
      step  <= '0;
    end else if (start_ok) begin
      state  <= SQ_BUSY;
      step   <= '0;
      base_q <= base;
      mode_q <= scan_mode;
    end else if (step_done) begin
      if (last_step) begin
        state <= SQ_IDLE;
        step  <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_last    <= 1'b0;
      res_discard <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      res_valid   <= step_done;
      res_last    <= step_done && last_step;
      res_discard <= step_done && discard_pend;
      if (step_done) res_chan <= chan_sel;
      if (start_clash) overrun <= 1'b1;
    end
  end

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !conv_req);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_en && !conv_done) |=> (conv_req && $stable(chan_sel)));
  // R11
  result_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_req && conv_done));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R2
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid);
  // R4
  no_bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(!cfg_err && conv_en));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int STEPS = SCAN_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_en,
  input  logic             scan_mode,
  input  logic             refp_ext,
  input  logic             refn_ext,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             start,
  input  logic             conv_done,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wr_err,
  output logic             cfg_err,
  output logic             overrun,
  output logic             conv_req,
  output logic [CH_W-1:0]  chan_sel,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan,
  output logic             res_last,
  output logic             res_discard
);
  logic step_done, discard_pend, code_bad, ref_clash;

  adc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .conv_en(conv_en), .res_evt(step_done), .cfg_q(cfg_q),
    .wr_err(wr_err), .discard_pend(discard_pend)
  );

  adc_cfg_check u_chk (
    .base(cfg_q[CH_W-1:0]), .scan_mode(scan_mode), .refp_ext(refp_ext),
    .refn_ext(refn_ext), .code_bad(code_bad), .ref_clash(ref_clash),
    .cfg_err(cfg_err)
  );

  adc_step_fsm #(.STEPS(STEPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .scan_mode(scan_mode),
    .base(cfg_q[CH_W-1:0]), .cfg_err(cfg_err), .start(start),
    .conv_done(conv_done), .discard_pend(discard_pend), .conv_req(conv_req),
    .chan_sel(chan_sel), .step_done(step_done), .res_valid(res_valid),
    .res_chan(res_chan), .res_last(res_last), .res_discard(res_discard),
    .overrun(overrun)
  );

  // R4
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (code_bad || ref_clash));
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b1, scan_mode = 1'b1, refp_ext = 1'b0, refn_ext = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0, conv_done = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_q;
  logic wr_err, cfg_err, overrun, conv_req, res_valid, res_last, res_discard;
  logic [4:0] chan_sel, res_chan;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .scan_mode(scan_mode),
    .refp_ext(refp_ext), .refn_ext(refn_ext), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .start(start), .conv_done(conv_done),
    .cfg_q(cfg_q), .wr_err(wr_err), .cfg_err(cfg_err), .overrun(overrun),
    .conv_req(conv_req), .chan_sel(chan_sel), .res_valid(res_valid),
    .res_chan(res_chan), .res_last(res_last), .res_discard(res_discard)
  );

  // {scan, refp, refn, expect_err, code[4:0]}
  localparam logic [8:0] VEC [16] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 5'd0},
    {1'b1, 1'b0, 1'b0, 1'b0, 5'd12},
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd13},
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd15},
    {1'b1, 1'b0, 1'b0, 1'b0, 5'd16},
    {1'b1, 1'b0, 1'b0, 1'b0, 5'd20},
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd21},
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd31},
    {1'b0, 1'b0, 1'b0, 1'b0, 5'd23},
    {1'b0, 1'b0, 1'b0, 1'b1, 5'd24},
    {1'b1, 1'b1, 1'b0, 1'b1, 5'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 5'd2},
    {1'b1, 1'b0, 1'b1, 1'b1, 5'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 5'd1},
    {1'b0, 1'b1, 1'b0, 1'b0, 5'd1},
    {1'b0, 1'b1, 1'b0, 1'b1, 5'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // at a negedge with conv_req expected high; converter answers after one wait cycle
  task automatic do_step(input string req, input int ch, input int last, input int disc);
    check({req, " req"}, int'(conv_req), 1);
    check({req, " chan_sel"}, int'(chan_sel), ch);
    @(negedge clk);
    check("R11 hold req", int'(conv_req), 1);
    check("R11 hold chan", int'(chan_sel), ch);
    check("R11 no early result", int'(res_valid), 0);
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    check({req, " res_valid"}, int'(res_valid), 1);
    check({req, " res_chan"}, int'(res_chan), ch);
    check({req, " res_last"}, int'(res_last), last);
    check({req, " res_discard"}, int'(res_discard), disc);
  endtask

  task automatic full_scan(input string req, input int base, input int n, input int disc_first);
    for (int s = 0; s < n; s++)
      do_step(req, base + s, (s == n - 1) ? 1 : 0, (s == 0) ? disc_first : 0);
    check({req, " idle after"}, int'(conv_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_q", int'(cfg_q), 0);
    check("R1 conv_req", int'(conv_req), 0);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 wr_err", int'(wr_err), 0);
    check("R1 overrun", int'(overrun), 0);
    pulse_start();
    full_scan("R1 first scan", 0, 4, 0);

    // R2 R3 R4 R8 table walk
    for (int i = 0; i < 16; i++) begin
      logic [8:0] v;
      int n;
      v = VEC[i];
      scan_mode = v[8]; refp_ext = v[7]; refn_ext = v[6];
      wr_cfg({3'b000, v[4:0]});
      check("R4 R8 cfg_err", int'(cfg_err), int'(v[5]));
      pulse_start();
      if (v[5]) begin
        check("R4 R8 start ignored", int'(conv_req), 0);
      end else begin
        n = v[8] ? 4 : 1;
        full_scan(v[8] ? "R2 scan" : "R3 single", int'(v[4:0]), n, 0);
      end
    end
    scan_mode = 1'b1; refp_ext = 1'b0; refn_ext = 1'b0;

    // R5 reserved bits
    wr_cfg(8'h03);
    wr_cfg(8'h25);
    check("R5 wr_err", int'(wr_err), 1);
    check("R5 cfg_q kept", int'(cfg_q), 3);
    @(negedge clk);
    check("R5 wr_err one cycle", int'(wr_err), 0);
    wr_cfg(8'h47);
    check("R5 bit6 wr_err", int'(wr_err), 1);
    check("R5 bit6 cfg_q kept", int'(cfg_q), 3);

    // R6 internal-source bit while enabled
    wr_cfg(8'h84);
    check("R6 wr_err", int'(wr_err), 1);
    check("R6 cfg_q kept", int'(cfg_q), 3);
    wr_cfg(8'h04);
    check("R6 same bit accepted", int'(cfg_q), 4);
    check("R6 no wr_err", int'(wr_err), 0);

    // R7 discard first result after internal source on
    conv_en = 1'b0;
    wr_cfg(8'h84);
    check("R7 accepted while off", int'(cfg_q), 8'h84);
    check("R7 no wr_err", int'(wr_err), 0);
    conv_en = 1'b1;
    wr_cfg(8'h84);
    check("R7 rewrite accepted", int'(wr_err), 0);
    pulse_start();
    full_scan("R7 discard", 4, 4, 1);
    pulse_start();
    full_scan("R7 later scan clean", 4, 4, 0);
    conv_en = 1'b0;
    wr_cfg(8'h04);
    check("R7 bit cleared", int'(cfg_q), 4);

    // R12 start while disabled
    pulse_start();
    check("R12 no req", int'(conv_req), 0);
    check("R12 no overrun", int'(overrun), 0);
    conv_en = 1'b1;
    @(negedge clk);
    check("R12 still idle", int'(conv_req), 0);

    // R9 overrun
    pulse_start();
    do_step("R9 step0", 4, 0, 0);
    pulse_start();
    check("R9 overrun set", int'(overrun), 1);
    check("R9 scan undisturbed", int'(chan_sel), 5);
    for (int s = 1; s < 4; s++) do_step("R9 rest", 4 + s, (s == 3) ? 1 : 0, 0);
    check("R9 idle", int'(conv_req), 0);
    repeat (2) @(negedge clk);
    check("R9 sticky", int'(overrun), 1);

    // R10 abort mid-scan
    pulse_start();
    do_step("R10 step0", 4, 0, 0);
    conv_en = 1'b0;
    conv_done = 1'b1;
    @(negedge clk);
    check("R10 req dropped", int'(conv_req), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 no result", int'(res_valid), 0);
    end
    conv_done = 1'b0;
    conv_en = 1'b1;
    pulse_start();
    full_scan("R10 restart", 4, 4, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule